// File: doc/BRIEF.md
# Serial Register Access Engine

This block bridges a byte-oriented asynchronous serial line to a simple parallel register bus inside a synthesizer control block. A host sends a command byte. Bit 7 of the command byte selects read (1) or write (0), and bits 5:0 hold a register address. The engine then moves the number of bytes that the addressed bank holds. After each step it answers the host with a standard control character, so the host always knows how far a transfer has got.

Banks at addresses below `WIDE_BANKS` are full words of `DATA_W` bits and carry `DATA_W/8` bytes, most significant byte first. Banks from `WIDE_BANKS` up to `MAP_SIZE-1` carry one byte. Any address at or above `MAP_SIZE` is refused. A write is held in the engine until the whole bank has arrived, and only then is it committed to the bus in one cycle. A read samples the bank once and streams it back to the host. The bit timing of the serial line comes from the `CLK_DIV` parameter, which gives the number of clocks per bit.

Top module: `uart_reg_bridge`

## Requirements
- R1: Both serial directions use one start bit (0), 8 data bits sent LSB first, one stop bit (1) and no parity, with a bit period of `CLK_DIV` clocks. `txd` idles high, and it is high after reset.
- R2: In a command byte, bit 7 = 1 requests a read and bit 7 = 0 requests a write. Bits 5:0 give the register address, which is driven on `bus_addr`.
- R3: A command whose address is at or above `MAP_SIZE` (default 16) is answered with NAK (0x15). No bus write follows, and the engine returns to waiting for a command.
- R4: Addresses below `WIDE_BANKS` (default 8) take 4 data bytes, most significant first. Addresses from `WIDE_BANKS` to `MAP_SIZE-1` take 1 byte, which lands in bits 7:0 of the write word with all upper bits zero.
- R5: The n-th correctly received data byte of a write (n = 1..4) is answered with 0x1F, 0x1E, 0x1D or 0x1C respectively.
- R6: Once the last byte of a write bank has arrived, `bus_wr` pulses for exactly one cycle with the full word on `bus_wdata`. ACK (0x06) follows the last separator.
- R7: A byte whose stop bit is sampled low is answered with NAK (0x15). The engine then waits for a new command, and a partly received bank is discarded without any bus write.
- R8: A read returns the bank bytes on `txd`, most significant byte first (1 byte for narrow banks), and then EOT (0x04).
- R9: The receiver checks the start bit at half a bit period. A low pulse on `rxd` shorter than that produces no byte and no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial data from the host |
| txd | output | 1 | Serial data to the host |
| bus_addr | output | ADDR_W | Register bus address |
| bus_wdata | output | DATA_W | Register bus write word |
| bus_wr | output | 1 | Register bus write strobe, one cycle |
| bus_rdata | input | DATA_W | Register bus read word, valid the cycle after `bus_addr` changes |

## Verification
The hardest situation to reach is a wide write that is cut short part-way. Two bytes must be accepted and acknowledged, and then the third must fail framing, so the engine holds a half-built word that must never reach the bus. The bench drives a third byte with its stop bit held low. It checks that the reply sequence is the two separators followed by NAK and that the write strobe never fires. It then reads the same bank back to show the old contents are intact. It also drives a sub-half-bit glitch on `rxd` and confirms that no reply appears.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam logic [7:0] CH_ACK = 8'h06;
  localparam logic [7:0] CH_NAK = 8'h15;
  localparam logic [7:0] CH_EOT = 8'h04;
  localparam logic [7:0] CH_IS1 = 8'h1F;  // later separators count down

  typedef enum logic [2:0] {
    P_CMD, P_WDATA, P_SEND, P_COMMIT, P_FETCH, P_LATCH, P_RDOUT
  } proto_st_e;
endpackage

// File: rtl/uart_rx_unit.sv
module uart_rx_unit #(
  parameter int CLK_DIV = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       rx_ferr
);
  localparam int CW   = $clog2(CLK_DIV);
  localparam int HALF = CLK_DIV / 2;

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_STOP, R_BREAK} rx_st_e;

  rx_st_e      st;
  logic [1:0]  sync;
  logic        rx_s;
  logic [CW-1:0] cnt;
  logic [2:0]  bitn;
  logic [7:0]  shreg;

  assign rx_s = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync     <= 2'b11;
      st       <= R_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      rx_ferr  <= 1'b0;
    end else begin
      sync     <= {sync[0], rxd};
      rx_valid <= 1'b0;
      case (st)
        R_IDLE: begin
          cnt <= '0;
          if (!rx_s) st <= R_START;
        end
        R_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rx_s ? R_IDLE : R_DATA;
          end else cnt <= cnt + 1'b1;
        end
        R_DATA: begin
          if (cnt == CW'(CLK_DIV - 1)) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[7:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == 3'd7) st <= R_STOP;
          end else cnt <= cnt + 1'b1;
        end
        R_STOP: begin
          if (cnt == CW'(CLK_DIV - 1)) begin
            cnt      <= '0;
            rx_valid <= 1'b1;
            rx_byte  <= shreg;
            rx_ferr  <= !rx_s;
            st       <= rx_s ? R_IDLE : R_BREAK;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (rx_s) st <= R_IDLE;  // wait for line to recover after a bad stop
        end
      endcase
    end
  end

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/uart_tx_unit.sv
module uart_tx_unit #(
  parameter int CLK_DIV = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_start,
  input  logic [7:0] tx_byte,
  output logic       tx_busy,
  output logic       txd
);
  localparam int CW = $clog2(CLK_DIV);

  logic [CW-1:0] cnt;
  logic [3:0]    nbit;
  logic [8:0]    shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_busy <= 1'b0;
      txd     <= 1'b1;
      cnt     <= '0;
      nbit    <= '0;
      shreg   <= '1;
    end else if (!tx_busy) begin
      if (tx_start) begin
        tx_busy <= 1'b1;
        txd     <= 1'b0;
        shreg   <= {1'b1, tx_byte};
        cnt     <= '0;
        nbit    <= '0;
      end
    end else if (cnt == CW'(CLK_DIV - 1)) begin
      cnt <= '0;
      if (nbit == 4'd9) begin
        tx_busy <= 1'b0;
      end else begin
        txd   <= shreg[0];
        shreg <= {1'b1, shreg[8:1]};
        nbit  <= nbit + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);
endmodule

// File: rtl/reg_proto_fsm.sv
module reg_proto_fsm
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int MAP_SIZE   = 16,
  parameter int WIDE_BANKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_ferr,
  input  logic              tx_busy,
  output logic              tx_start,
  output logic [7:0]        tx_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int BYTES = DATA_W / 8;
  localparam int NB_W  = $clog2(BYTES) + 1;
  localparam logic [ADDR_W:0] MAP_LIM  = (ADDR_W + 1)'(MAP_SIZE);
  localparam logic [ADDR_W:0] WIDE_LIM = (ADDR_W + 1)'(WIDE_BANKS);

  proto_st_e         st, ret_st;
  logic [7:0]        reply;
  logic [NB_W-1:0]   nbytes, idx;
  logic [DATA_W-1:0] acc;
  logic              can_send;
  logic [ADDR_W:0]   cmd_addr;

  assign can_send = !tx_busy && !tx_start;
  assign cmd_addr = {1'b0, rx_byte[ADDR_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= P_CMD;
      ret_st    <= P_CMD;
      reply     <= '0;
      nbytes    <= '0;
      idx       <= '0;
      acc       <= '0;
      tx_start  <= 1'b0;
      tx_byte   <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_wr    <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      bus_wr   <= 1'b0;
      case (st)
        P_CMD: if (rx_valid) begin
          acc <= '0;
          idx <= '0;
          if (rx_ferr || cmd_addr >= MAP_LIM) begin
            reply  <= CH_NAK;
            ret_st <= P_CMD;
            st     <= P_SEND;
          end else begin
            bus_addr <= rx_byte[ADDR_W-1:0];
            nbytes   <= (cmd_addr < WIDE_LIM) ? NB_W'(BYTES) : NB_W'(1);
            st       <= rx_byte[7] ? P_FETCH : P_WDATA;
          end
        end
        P_WDATA: if (rx_valid) begin
          if (rx_ferr) begin
            reply  <= CH_NAK;
            ret_st <= P_CMD;
          end else begin
            acc    <= {acc[DATA_W-9:0], rx_byte};
            idx    <= idx + 1'b1;
            reply  <= CH_IS1 - 8'(idx);
            ret_st <= (idx + 1'b1 == nbytes) ? P_COMMIT : P_WDATA;
          end
          st <= P_SEND;
        end
        P_SEND: if (can_send) begin
          tx_start <= 1'b1;
          tx_byte  <= reply;
          st       <= ret_st;
        end
        P_COMMIT: begin
          bus_wr    <= 1'b1;
          bus_wdata <= acc;
          reply     <= CH_ACK;
          ret_st    <= P_CMD;
          st        <= P_SEND;
        end
        P_FETCH: st <= P_LATCH;
        P_LATCH: begin
          acc <= (nbytes == NB_W'(BYTES)) ? bus_rdata : (bus_rdata << (DATA_W - 8));
          idx <= '0;
          st  <= P_RDOUT;
        end
        default: if (can_send) begin
          tx_start <= 1'b1;
          tx_byte  <= acc[DATA_W-1 -: 8];
          acc      <= acc << 8;
          idx      <= idx + 1'b1;
          if (idx + 1'b1 == nbytes) begin
            reply  <= CH_EOT;
            ret_st <= P_CMD;
            st     <= P_SEND;
          end
        end
      endcase
    end
  end

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !bus_wr);
  // R3
  wr_addr_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> ({1'b0, bus_addr} < MAP_LIM));
  // R1
  tx_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !tx_busy);
  // R7
  ferr_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ferr) |=> !bus_wr);
endmodule

// File: rtl/uart_reg_bridge.sv
module uart_reg_bridge #(
  parameter int CLK_DIV    = 16,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int MAP_SIZE   = 16,
  parameter int WIDE_BANKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  output logic              txd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic       rx_valid, rx_ferr, tx_start, tx_busy;
  logic [7:0] rx_byte, tx_byte;

  uart_rx_unit #(.CLK_DIV(CLK_DIV)) u_rx (
    .clk(clk), .rst(rst), .rxd(rxd),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ferr(rx_ferr)
  );

  uart_tx_unit #(.CLK_DIV(CLK_DIV)) u_tx (
    .clk(clk), .rst(rst), .tx_start(tx_start), .tx_byte(tx_byte),
    .tx_busy(tx_busy), .txd(txd)
  );

  reg_proto_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MAP_SIZE(MAP_SIZE), .WIDE_BANKS(WIDE_BANKS)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ferr(rx_ferr),
    .tx_busy(tx_busy), .tx_start(tx_start), .tx_byte(tx_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: tb/tb_uart_reg_bridge.sv
module tb_uart_reg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic        txd;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic [31:0] bus_rdata;

  logic [31:0] regs [0:63];
  int          wr_cnt = 0;
  logic [7:0]  log_q [0:255];
  int          log_n = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_reg_bridge #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .rxd(rxd), .txd(txd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata)
  );

  // bench-side register bank
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) regs[i] <= 32'h0;
    end else if (bus_wr) begin
      regs[bus_addr] <= bus_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end
  assign bus_rdata = regs[bus_addr];

  // host-side receive monitor
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        repeat (DIV / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          b[i] = txd;
        end
        repeat (DIV) @(negedge clk);
        log_q[log_n[7:0]] = b;
        log_n = log_n + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stop_ok);
    @(negedge clk);
    rxd = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (DIV) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic wait_log(input int target, input string req);
    int t = 0;
    while (log_n < target && t < 20 * DIV * 10) begin
      @(negedge clk);
      t++;
    end
    check({req, " reply count"}, 32'(log_n), 32'(target));
    repeat (2 * DIV) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check("R1 txd idle high after reset", 32'(txd), 32'd1);
    check("R6 no write at reset", 32'(wr_cnt), 32'd0);
  endtask

  task automatic t_write_wide();
    int base = log_n;
    int w0 = wr_cnt;
    send_byte(8'h03, 1'b1);  // R2 write, address 3
    send_byte(8'hA1, 1'b1);
    send_byte(8'hB2, 1'b1);
    send_byte(8'hC3, 1'b1);
    send_byte(8'hD4, 1'b1);
    wait_log(base + 5, "R5");
    check("R5 IS1", 32'(log_q[base]), 32'h1F);
    check("R5 IS2", 32'(log_q[base + 1]), 32'h1E);
    check("R5 IS3", 32'(log_q[base + 2]), 32'h1D);
    check("R5 IS4", 32'(log_q[base + 3]), 32'h1C);
    check("R6 ACK", 32'(log_q[base + 4]), 32'h06);
    check("R4 wide word MSB first", regs[3], 32'hA1B2C3D4);
    check("R6 single write", 32'(wr_cnt - w0), 32'd1);
  endtask

  task automatic t_write_narrow();
    int base = log_n;
    send_byte(8'h0A, 1'b1);  // narrow bank 10
    send_byte(8'h5A, 1'b1);
    wait_log(base + 2, "R4");
    check("R5 narrow IS1", 32'(log_q[base]), 32'h1F);
    check("R6 narrow ACK", 32'(log_q[base + 1]), 32'h06);
    check("R4 narrow zero-extended", regs[10], 32'h0000005A);
  endtask

  task automatic t_read_wide();
    int base = log_n;
    send_byte(8'h83, 1'b1);  // R2 read, address 3
    wait_log(base + 5, "R8");
    check("R8 byte0", 32'(log_q[base]), 32'hA1);
    check("R8 byte1", 32'(log_q[base + 1]), 32'hB2);
    check("R8 byte2", 32'(log_q[base + 2]), 32'hC3);
    check("R8 byte3", 32'(log_q[base + 3]), 32'hD4);
    check("R8 EOT", 32'(log_q[base + 4]), 32'h04);
  endtask

  task automatic t_read_narrow();
    int base = log_n;
    send_byte(8'h8A, 1'b1);
    wait_log(base + 2, "R8");
    check("R8 narrow byte", 32'(log_q[base]), 32'h5A);
    check("R8 narrow EOT", 32'(log_q[base + 1]), 32'h04);
  endtask

  task automatic t_bad_addr();
    int base = log_n;
    int w0 = wr_cnt;
    send_byte(8'h14, 1'b1);  // write to 20: out of map
    wait_log(base + 1, "R3");
    check("R3 NAK on write", 32'(log_q[base]), 32'h15);
    send_byte(8'hBF, 1'b1);  // read 63
    wait_log(base + 2, "R3");
    check("R3 NAK on read", 32'(log_q[base + 1]), 32'h15);
    check("R3 no write", 32'(wr_cnt - w0), 32'd0);
  endtask

  task automatic t_frame_err();
    int base = log_n;
    int w0 = wr_cnt;
    send_byte(8'h05, 1'b1);
    send_byte(8'h11, 1'b1);
    send_byte(8'h22, 1'b1);
    send_byte(8'h33, 1'b0);  // stop bit low
    wait_log(base + 3, "R7");
    check("R7 IS1 before error", 32'(log_q[base]), 32'h1F);
    check("R7 IS2 before error", 32'(log_q[base + 1]), 32'h1E);
    check("R7 NAK", 32'(log_q[base + 2]), 32'h15);
    check("R7 no partial write", 32'(wr_cnt - w0), 32'd0);
    send_byte(8'h85, 1'b1);  // engine back to command wait
    wait_log(base + 8, "R7");
    check("R7 bank untouched b0", 32'(log_q[base + 3]), 32'h00);
    check("R7 bank untouched b3", 32'(log_q[base + 6]), 32'h00);
    check("R7 EOT after readback", 32'(log_q[base + 7]), 32'h04);
    send_byte(8'h46, 1'b0);  // bad command framing
    wait_log(base + 9, "R7");
    check("R7 NAK on bad command", 32'(log_q[base + 8]), 32'h15);
  endtask

  task automatic t_glitch();
    int base = log_n;
    @(negedge clk);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (30 * DIV) @(negedge clk);
    check("R9 glitch gives no reply", 32'(log_n), 32'(base));
    send_byte(8'h8A, 1'b1);
    wait_log(base + 2, "R9");
    check("R9 read after glitch", 32'(log_q[base]), 32'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_wide();
    t_write_narrow();
    t_read_wide();
    t_read_narrow();
    t_bad_addr();
    t_frame_err();
    t_glitch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule